// File: doc/BRIEF.md
# Shift-and-Add Multiplier Register Datapath

This block holds the storage and arithmetic of an unsigned shift-and-add multiplier that works on `WIDTH`-bit operands (four by default). It keeps a multiplicand register, an accumulator, a multiplier register that collects the low half of the product, and a single carry flag. A separate sequencing block drives it with three commands: load, accumulate and shift. At most one of these is active in any cycle. The block reads the least significant bit of the multiplier register to decide between accumulating and shifting, and it exposes the accumulator and multiplier register together as the double-width product.

Inside the block the three commands are packed into one 2-bit operation code, and every register is steered by that code alone. There are four operations. HOLD (code 00) is selected when no command is active. LOAD (01) comes from the load command, ACCUM (10) from the accumulate command and SHIFT (11) from the shift command. The register bank decodes the code with a single case statement, one arm per operation. A `WIDTH`-bit ripple adder forms the accumulator plus multiplicand for the ACCUM arm.

A full multiplication is one LOAD, then `WIDTH` rounds. In each round there is an ACCUM when the multiplier LSB is 1, and then one SHIFT.

Top module: `shift_add_datapath`

## Requirements
- R1: The operation code is 00 when no command is active, 01 for load, 10 for accumulate and 11 for shift. The load, accumulate and shift inputs are never active together.
- R2: HOLD (no command) leaves the multiplicand, carry, accumulator and multiplier register unchanged, so `product` and `mult_lsb` keep their values.
- R3: LOAD copies `opnd_a` into the multiplicand and `opnd_b` into the multiplier register, and clears the accumulator and the carry. The next `product` is `{0, opnd_b}`.
- R4: ACCUM writes the low `WIDTH` bits of accumulator + multiplicand (unsigned) into the accumulator and the carry-out into the carry flag. The multiplier register and the multiplicand are kept.
- R5: SHIFT moves the chain {carry, accumulator, multiplier register} right by one bit, drops the LSB of the multiplier register, and clears the carry.
- R6: A carry produced by ACCUM enters the accumulator MSB on the following SHIFT. Example: load A=15, B=1, then accumulate twice, then shift, which gives product 0xF0.
- R7: The multiplicand changes only on LOAD.
- R8: A synchronous reset (`rst` high at a clock edge) clears every register, so `product` is 0 on the next cycle.
- R9: LOAD followed by `WIDTH` rounds of (ACCUM if `mult_lsb`, then SHIFT) leaves `product` = A × B for all operand pairs.
- R10: `opnd_a` and `opnd_b` have no effect in any cycle other than a LOAD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opnd_a | input | WIDTH | Multiplicand operand, sampled on LOAD |
| opnd_b | input | WIDTH | Multiplier operand, sampled on LOAD |
| cmd_load | input | 1 | Load command |
| cmd_accum | input | 1 | Accumulate command |
| cmd_shift | input | 1 | Shift command |
| mult_lsb | output | 1 | Current LSB of the multiplier register |
| product | output | 2*WIDTH | {accumulator, multiplier register} |

## Verification
The hardest state to reach is a set carry flag that is then consumed by a shift. Reaching it needs the accumulator to overflow first, and in a normal multiply that happens only with large operands on a round whose LSB is 1. The bench reaches it in two ways. A directed sequence overflows the accumulator with two back-to-back accumulates. Then a long run of random commands, with random operands on every cycle, chains accumulates freely, so carries, holds and ignored operand changes all occur, while a behavioural model is compared against the outputs on every clock.

// File: rtl/shift_add_pkg.sv
package shift_add_pkg;

    // 2-bit operation code shared by encoder and register bank
    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_ACCUM = 2'b10,
        OP_SHIFT = 2'b11
    } op_code_e;

endpackage

// File: rtl/cmd_encoder.sv
module cmd_encoder
    import shift_add_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_load,
    input  logic     cmd_accum,
    input  logic     cmd_shift,
    output op_code_e op_code
);

    // Commands are mutually exclusive, so each code bit is an OR of two of them
    always_comb begin
        op_code = op_code_e'({cmd_accum | cmd_shift, cmd_load | cmd_shift});
    end

    AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_load, cmd_accum, cmd_shift})); // R1

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cmd_load | cmd_accum | cmd_shift) |-> op_code == OP_HOLD); // R1

endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);

    logic [WIDTH:0] chain;

    assign chain[0] = 1'b0;

    // One full-adder cell per bit
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign sum[i]      = lhs[i] ^ rhs[i] ^ chain[i];
        assign chain[i+1]  = (lhs[i] & rhs[i]) | (chain[i] & (lhs[i] ^ rhs[i]));
    end

    assign carry_out = chain[WIDTH];

endmodule

// File: rtl/operand_regs.sv
module operand_regs
    import shift_add_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  op_code_e         op_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [WIDTH-1:0] add_sum,
    input  logic             add_carry,
    output logic [WIDTH-1:0] mcand_q,
    output logic [WIDTH-1:0] accum_q,
    output logic [WIDTH-1:0] mplier_q,
    output logic             carry_q
);

    logic [WIDTH-1:0] mcand_d, accum_d, mplier_d;
    logic             carry_d;

    always_comb begin
        mcand_d  = mcand_q;
        accum_d  = accum_q;
        mplier_d = mplier_q;
        carry_d  = carry_q;
        unique case (op_code)
            OP_HOLD: begin
            end
            OP_LOAD: begin
                mcand_d  = opnd_a;
                accum_d  = '0;
                mplier_d = opnd_b;
                carry_d  = 1'b0;
            end
            OP_ACCUM: begin
                accum_d  = add_sum;
                carry_d  = add_carry;
            end
            OP_SHIFT: begin
                accum_d  = {carry_q, accum_q[WIDTH-1:1]};
                mplier_d = {accum_q[0], mplier_q[WIDTH-1:1]};
                carry_d  = 1'b0;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q  <= '0;
            accum_q  <= '0;
            mplier_q <= '0;
            carry_q  <= 1'b0;
        end else begin
            mcand_q  <= mcand_d;
            accum_q  <= accum_d;
            mplier_q <= mplier_d;
            carry_q  <= carry_d;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_HOLD |=> $stable(accum_q) && $stable(mplier_q) && $stable(carry_q)); // R2

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_LOAD |=> accum_q == '0 && !carry_q && mplier_q == $past(opnd_b)); // R3

    AST_ACCUM_KEEPS_MPLIER: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_ACCUM |=> $stable(mplier_q)); // R4

    AST_SHIFT_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_SHIFT |=> !carry_q); // R5

    AST_CARRY_INTO_MSB: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_SHIFT |=> accum_q[WIDTH-1] == $past(carry_q)); // R6

    AST_MCAND_KEPT: assert property (@(posedge clk) disable iff (rst)
        op_code != OP_LOAD |=> $stable(mcand_q)); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> accum_q == '0 && mplier_q == '0 && mcand_q == '0 && !carry_q); // R8

endmodule

// File: rtl/shift_add_datapath.sv
module shift_add_datapath
    import shift_add_pkg::*;
#(
    parameter int WIDTH = 4,
    localparam int PROD_W = 2 * WIDTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIDTH-1:0]  opnd_a,
    input  logic [WIDTH-1:0]  opnd_b,
    input  logic              cmd_load,
    input  logic              cmd_accum,
    input  logic              cmd_shift,
    output logic              mult_lsb,
    output logic [PROD_W-1:0] product
);

    op_code_e         op_code;
    logic [WIDTH-1:0] mcand_q, accum_q, mplier_q;
    logic             carry_q;
    logic [WIDTH-1:0] add_sum;
    logic             add_carry;

    cmd_encoder u_enc (
        .clk       (clk),
        .rst       (rst),
        .cmd_load  (cmd_load),
        .cmd_accum (cmd_accum),
        .cmd_shift (cmd_shift),
        .op_code   (op_code)
    );

    ripple_adder #(.WIDTH(WIDTH)) u_add (
        .lhs       (accum_q),
        .rhs       (mcand_q),
        .sum       (add_sum),
        .carry_out (add_carry)
    );

    operand_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .op_code   (op_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .add_sum   (add_sum),
        .add_carry (add_carry),
        .mcand_q   (mcand_q),
        .accum_q   (accum_q),
        .mplier_q  (mplier_q),
        .carry_q   (carry_q)
    );

    assign mult_lsb = mplier_q[0];
    assign product  = {accum_q, mplier_q};

    AST_ACCUM_SUM: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_ACCUM |=>
        {carry_q, accum_q} == {1'b0, $past(accum_q)} + {1'b0, $past(mcand_q)}); // R4

endmodule

// File: tb/shift_add_datapath_test.sv
module shift_add_datapath_test;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opnd_a = '0, opnd_b = '0;
    logic         cmd_load = 1'b0, cmd_accum = 1'b0, cmd_shift = 1'b0;
    logic         mult_lsb;
    logic [2*W-1:0] product;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state, kept as plain integers
    int rm = 0, rc = 0, ra = 0, rq = 0;

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    shift_add_datapath #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .cmd_load(cmd_load), .cmd_accum(cmd_accum), .cmd_shift(cmd_shift),
        .mult_lsb(mult_lsb), .product(product)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive command (0 none,1 load,2 accum,3 shift), advance model, compare
    task automatic step(input int op, input int a, input int b);
        string tag;
        int chain;
        opnd_a    = W'(a);
        opnd_b    = W'(b);
        cmd_load  = (op == 1);
        cmd_accum = (op == 2);
        cmd_shift = (op == 3);
        @(posedge clk);
        case (op)
            1: begin rm = a & 15; rq = b & 15; ra = 0; rc = 0; tag = "R3"; end
            2: begin chain = ra + rm; ra = chain & 15; rc = chain >> 4; tag = "R4"; end
            3: begin
                chain = (rc << 8) | (ra << 4) | rq;
                chain = chain >> 1;
                ra = (chain >> 4) & 15; rq = chain & 15; rc = 0; tag = "R5";
            end
            default: tag = "R2";
        endcase
        @(negedge clk);
        if (op != 1) tag = {tag, "/R10/R7"};
        check(tag, int'(product), (ra << 4) | rq);
        check(tag, int'(mult_lsb), rq & 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset", int'(product), 0);
        rst = 1'b0;

        // R6: carry from accumulate enters accumulator MSB on shift
        step(1, 15, 1);
        step(2, 0, 0);
        step(2, 0, 0);
        step(3, 0, 0);
        check("R6 carry chain", int'(product), 'hF0);

        // R2: holds with operands wiggling
        step(0, 9, 6);
        step(0, 3, 12);

        // R9 with R1 encoding: full multiply of every pair, operands scrambled after load
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(1, a, b);
                for (int k = 0; k < W; k++) begin
                    if (rq & 1) step(2, ~a, ~b);
                    step(3, b, a);
                end
                check("R9 product", int'(product), a * b);
            end
        end

        // Random command stream, random operands on every cycle
        for (int n = 0; n < 1500; n++) begin
            step($urandom_range(3), $urandom_range(15), $urandom_range(15));
        end

        // R8: reset mid-operation clears everything
        step(1, 13, 11);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rm = 0; ra = 0; rq = 0; rc = 0;
        check("R8 reset mid-op", int'(product), 0);
        step(2, 7, 7);   // multiplicand cleared by reset, so sum stays 0

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule